// File: doc/BRIEF.md
# Translation Buffer with Hardware Page-Table Walk

This block translates virtual addresses into physical addresses. It keeps a small fully associative buffer of recent translations. Each slot pairs a page number (the key) with a frame number (the value). When a request arrives, its page number is compared against every valid key at once. On a match, the block joins the stored frame number with the page offset and answers without touching memory.

When no key matches, the block fetches the entry from a single-level page table in memory. The entry address is the table base input plus the page number. The block issues one read on a simple request/response port and waits for the data. It then checks the present bit. If the bit is clear, it reports a page fault and leaves the buffer unchanged. If the bit is set, it writes the new pair into the buffer and returns the physical address.

A refill goes into an empty slot first. When every slot is full, it replaces the slot used least recently. A flush input empties the whole buffer, for use when the table base is reloaded. Only one request is handled at a time.

Top module: `tlb_walker`

## Requirements
- R1: After reset the buffer holds no valid translations, `req_ready` is 1, and both `resp_valid` and `mem_req_valid` are 0.
- R2: A request whose page number is held in the buffer is answered two clocks after acceptance, with `resp_hit`=1, `resp_fault`=0 and `resp_paddr` = {stored frame, request offset}. It issues no memory read.
- R3: A request that misses raises `mem_req_valid` for exactly one cycle, with `mem_req_addr` = `pt_base` + page number, taken modulo 2^MADDR_W. This happens in the cycle after the lookup.
- R4: A table entry has its present bit at position PTE_W-1 and its frame number in bits PFN_W-1:0. When the fetched entry is present, the response has `resp_hit`=0, `resp_fault`=0 and `resp_paddr` = {fetched frame, offset}. A later request to the same page is then a hit.
- R5: When the fetched entry's present bit is 0, the response has `resp_fault`=1 and `resp_hit`=0. Nothing is installed, so repeating the request performs another memory read.
- R6: From acceptance until the cycle its response is presented, `req_ready` is 0. Requests offered during that time are ignored and produce no response.
- R7: A refill writes the lowest-numbered empty slot if one exists. Otherwise it replaces the slot whose last hit or refill is oldest.
- R8: A one-cycle `flush` pulse invalidates every slot by the next cycle, so previously cached pages miss. If a refill falls in the same cycle, the flush wins.
- R9: `resp_valid` is a one-cycle pulse, and each accepted request receives exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all buffer slots |
| pt_base | input | MADDR_W | Page-table base word address; held stable during a walk |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VPN_W+OFS_W | Virtual address {page, offset} |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response served from the buffer |
| resp_fault | output | 1 | Page not present |
| resp_paddr | output | PFN_W+OFS_W | Physical address {frame, offset} |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_addr | output | MADDR_W | Page-table entry word address |
| mem_resp_valid | input | 1 | Read data returned |
| mem_resp_data | input | PTE_W | Page-table entry |

## Verification
The first request to a page and a repeat of it to a different offset separate the walk path from the buffer path, and show that a refill is later found. Pages whose table entry is absent are requested twice, which shows that a fault leaves the buffer untouched. Filling all four slots, touching one, and then missing shows that empty slots are used first and that eviction follows recency rather than slot order. A request held high during a walk, a flush, and a changed table base show that busy requests are ignored, that a flush empties the buffer, and that walk addresses track the base.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WALK_REQ,
    ST_WALK_WAIT,
    ST_REFILL,
    ST_FAULT
  } walk_state_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 4,
  parameter int KEY_W = 6,
  parameter int VAL_W = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [KEY_W-1:0] lk_key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [VAL_W-1:0] hit_val,
  output logic [N-1:0]     valid_vec
);
  logic [KEY_W-1:0] keys [N];
  logic [VAL_W-1:0] vals [N];
  logic [N-1:0]     match;

  // valid bits: reset and flush clear all, refill sets one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
    end else if (flush) begin
      valid_vec <= '0;
    end else if (wr_en) begin
      valid_vec[wr_idx] <= 1'b1;
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        keys[i] <= wr_key;
        vals[i] <= wr_val;
      end
    end
  end

  // parallel compare
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_vec[g] && (keys[g] == lk_key);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    hit_val = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        hit_val = hit_val | vals[i];
      end
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     valid_vec,
  output logic [IDX_W-1:0] victim
);
  // age 0 = most recent, N-1 = oldest; ages always form a permutation
  logic [IDX_W-1:0] age [N];
  logic [IDX_W-1:0] age_t;

  assign age_t = age[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (touch_idx == IDX_W'(i))  age[i] <= '0;
        else if (age[i] < age_t)     age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (age[i] == IDX_W'(N - 1)) victim = IDX_W'(i);
    end
    if (!(&valid_vec)) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!valid_vec[i]) victim = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
  import tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_fire,
  input  logic        lookup_hit,
  input  logic        mem_resp_valid,
  input  logic        pte_present,
  output walk_state_t state
);
  walk_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:      if (req_fire) state_d = ST_LOOKUP;
      ST_LOOKUP:    state_d = lookup_hit ? ST_IDLE : ST_WALK_REQ;
      ST_WALK_REQ:  state_d = ST_WALK_WAIT;
      ST_WALK_WAIT: if (mem_resp_valid) state_d = pte_present ? ST_REFILL : ST_FAULT;
      ST_REFILL:    state_d = ST_IDLE;
      ST_FAULT:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 6,
  parameter int PFN_W   = 6,
  parameter int OFS_W   = 10,
  parameter int MADDR_W = 16,
  parameter int PTE_W   = 16,
  localparam int VA_W  = VPN_W + OFS_W,
  localparam int PA_W  = PFN_W + OFS_W,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [MADDR_W-1:0] pt_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               resp_fault,
  output logic [PA_W-1:0]    resp_paddr,
  output logic               mem_req_valid,
  output logic [MADDR_W-1:0] mem_req_addr,
  input  logic               mem_resp_valid,
  input  logic [PTE_W-1:0]   mem_resp_data
);
  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  walk_state_t       state;
  logic              req_fire;
  logic [VA_W-1:0]   va_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [PFN_W-1:0]  lk_frame;
  logic [ENTRIES-1:0] ent_valid;
  logic [IDX_W-1:0]  victim;
  logic [PFN_W-1:0]  pte_frame_q;
  logic              pte_capture;
  logic              in_lookup, in_refill, in_fault;
  logic              touch;
  logic [IDX_W-1:0]  touch_idx;
  logic              rsp_en;
  logic              rsp_hit_d, rsp_fault_d;
  logic [PA_W-1:0]   rsp_pa_d;
  logic              unused_pte;

  assign unused_pte = ^mem_resp_data;

  assign req_ready = rst_s && (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign vpn_q     = va_q[VA_W-1:OFS_W];
  assign ofs_q     = va_q[OFS_W-1:0];
  assign in_lookup = (state == ST_LOOKUP);
  assign in_refill = (state == ST_REFILL);
  assign in_fault  = (state == ST_FAULT);
  assign pte_capture = (state == ST_WALK_WAIT) && mem_resp_valid;

  tlb_walk_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_s),
    .req_fire       (req_fire),
    .lookup_hit     (lk_hit),
    .mem_resp_valid (mem_resp_valid),
    .pte_present    (mem_resp_data[PTE_W-1]),
    .state          (state)
  );

  tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W), .VAL_W(PFN_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_s),
    .flush     (flush),
    .wr_en     (in_refill),
    .wr_idx    (victim),
    .wr_key    (vpn_q),
    .wr_val    (pte_frame_q),
    .lk_key    (vpn_q),
    .hit       (lk_hit),
    .hit_idx   (lk_idx),
    .hit_val   (lk_frame),
    .valid_vec (ent_valid)
  );

  assign touch     = (in_lookup && lk_hit) || in_refill;
  assign touch_idx = in_refill ? victim : lk_idx;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk       (clk),
    .rst_n     (rst_s),
    .touch     (touch),
    .touch_idx (touch_idx),
    .valid_vec (ent_valid),
    .victim    (victim)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (req_fire) va_q <= req_vaddr;
  end

  // fetched frame capture
  always_ff @(posedge clk) begin
    if (pte_capture) pte_frame_q <= mem_resp_data[PFN_W-1:0];
  end

  // walk read port
  assign mem_req_valid = (state == ST_WALK_REQ);
  assign mem_req_addr  = pt_base + MADDR_W'(vpn_q);

  // response next values
  always_comb begin
    rsp_en      = (in_lookup && lk_hit) || in_refill || in_fault;
    rsp_hit_d   = in_lookup;
    rsp_fault_d = in_fault;
    if (in_lookup)      rsp_pa_d = {lk_frame, ofs_q};
    else if (in_refill) rsp_pa_d = {pte_frame_q, ofs_q};
    else                rsp_pa_d = '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) resp_valid <= 1'b0;
    else        resp_valid <= rsp_en;
  end

  always_ff @(posedge clk) begin
    if (rsp_en) begin
      resp_hit   <= rsp_hit_d;
      resp_fault <= rsp_fault_d;
      resp_paddr <= rsp_pa_d;
    end
  end
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         req_valid,
  input logic         req_ready,
  input logic         resp_valid,
  input logic         resp_hit,
  input logic         resp_fault,
  input logic         mem_req_valid,
  input logic [N-1:0] valid_vec
);
  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_walk_read_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  assert_fault_not_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_hit && resp_fault));

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_read_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
endmodule

bind tlb_walker tlb_walker_chk #(.N(ENTRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .resp_fault    (resp_fault),
  .mem_req_valid (mem_req_valid),
  .valid_vec     (ent_valid)
);

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb;
  localparam int VPN_W = 6, PFN_W = 6, OFS_W = 10, MADDR_W = 16, PTE_W = 16;
  localparam int VA_W = VPN_W + OFS_W, PA_W = PFN_W + OFS_W;

  logic clk, rst_n, flush, req_valid, req_ready;
  logic [MADDR_W-1:0] pt_base;
  logic [VA_W-1:0] req_vaddr;
  logic resp_valid, resp_hit, resp_fault;
  logic [PA_W-1:0] resp_paddr;
  logic mem_req_valid, mem_resp_valid;
  logic [MADDR_W-1:0] mem_req_addr;
  logic [PTE_W-1:0] mem_resp_data;

  int total = 0, bad = 0, pushed = 0, done_cnt = 0;
  bit finished = 0;

  logic        q_hit [$];
  logic        q_flt [$];
  logic [PA_W-1:0] q_pa [$];
  string       q_tag [$];
  logic [MADDR_W-1:0] q_maddr [$];

  tlb_walker u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // page table contents: absent when address low three bits are all ones
  function automatic logic [PTE_W-1:0] pte_of(input logic [MADDR_W-1:0] a);
    logic [PFN_W-1:0] fr;
    fr = PFN_W'(a * 5 + 3);
    return {(a[2:0] != 3'b111), {(PTE_W-1-PFN_W){1'b0}}, fr};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: latency of two cycles
  initial begin
    mem_resp_valid = 0;
    mem_resp_data  = '0;
    forever begin
      logic [MADDR_W-1:0] a;
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        a = mem_req_addr;
        if (q_maddr.size() == 0) begin
          check(0, "R2 unexpected memory read", a, 0);
        end else begin
          logic [MADDR_W-1:0] e;
          e = q_maddr.pop_front();
          check(a == e, "R3 walk address", a, e);
        end
        @(negedge clk);
        @(negedge clk);
        mem_resp_valid = 1;
        mem_resp_data  = pte_of(a);
        @(negedge clk);
        mem_resp_valid = 0;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q_hit.size() == 0) begin
        check(0, "R9 unexpected response", resp_paddr, 0);
      end else begin
        logic eh, ef;
        logic [PA_W-1:0] ep;
        string t;
        eh = q_hit.pop_front(); ef = q_flt.pop_front();
        ep = q_pa.pop_front();  t  = q_tag.pop_front();
        check(resp_hit == eh, {t, " hit flag"}, resp_hit, eh);
        check(resp_fault == ef, {t, " fault flag"}, resp_fault, ef);
        if (!ef) check(resp_paddr == ep, {t, " paddr"}, resp_paddr, ep);
      end
      done_cnt++;
    end
  end

  task automatic run_req(input logic [VPN_W-1:0] vpn, input logic [OFS_W-1:0] ofs,
                         input bit exp_hit, input string tag, input bit hold = 0);
    logic [MADDR_W-1:0] a;
    logic [PTE_W-1:0] d;
    bit ready_seen;
    a = pt_base + MADDR_W'(vpn);
    d = pte_of(a);
    q_hit.push_back(exp_hit);
    q_flt.push_back(!exp_hit && !d[PTE_W-1]);
    q_pa.push_back({d[PFN_W-1:0], ofs});
    q_tag.push_back(tag);
    if (!exp_hit) q_maddr.push_back(a);
    pushed++;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, ofs};
    @(negedge clk);
    if (hold) begin
      ready_seen = 0;
      req_vaddr = {~vpn, ~ofs};
      while (!resp_valid) begin
        if (req_ready) ready_seen = 1;
        @(negedge clk);
      end
      req_valid = 0;
      check(!ready_seen, "R6 ready low while busy", ready_seen, 0);
    end else begin
      req_valid = 0;
    end
    while (done_cnt < pushed) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, pushed);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; req_valid = 0; req_vaddr = '0; pt_base = 16'h0100;
    repeat (3) @(negedge clk);
    check(resp_valid == 0, "R1 resp_valid in reset", resp_valid, 0);
    check(mem_req_valid == 0, "R1 mem_req_valid in reset", mem_req_valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(req_ready == 1, "R1 ready after reset", req_ready, 1);
    check(resp_valid == 0, "R1 no response after reset", resp_valid, 0);

    run_req(6'd5, 10'h012, 0, "R4 first touch refill");
    run_req(6'd5, 10'h3FF, 1, "R2 repeat hit");
    run_req(6'd7, 10'h001, 0, "R5 absent page");
    run_req(6'd7, 10'h002, 0, "R5 absent page again walks");
    run_req(6'd9, 10'h100, 0, "R6 busy walk", 1);
    repeat (4) @(negedge clk);
    check(done_cnt == pushed, "R6 no extra response", done_cnt, pushed);
    run_req(6'd9, 10'h000, 1, "R4 refill after busy");

    // fill remaining empty slots, then all must hit
    run_req(6'd10, 10'h055, 0, "R7 fill slot");
    run_req(6'd11, 10'h0AA, 0, "R7 fill slot");
    run_req(6'd5,  10'h001, 1, "R7 empty-first kept 5");
    run_req(6'd9,  10'h001, 1, "R7 empty-first kept 9");
    run_req(6'd10, 10'h001, 1, "R7 empty-first kept 10");
    run_req(6'd11, 10'h001, 1, "R7 empty-first kept 11");
    // recency order oldest->newest: 5,9,10,11; touch 5 so 9 is oldest
    run_req(6'd5,  10'h002, 1, "R7 touch 5");
    run_req(6'd12, 10'h003, 0, "R7 miss evicts oldest");
    run_req(6'd12, 10'h004, 1, "R7 new page held");
    run_req(6'd5,  10'h005, 1, "R7 touched page kept");
    run_req(6'd10, 10'h006, 1, "R7 page 10 kept");
    run_req(6'd11, 10'h007, 1, "R7 page 11 kept");
    run_req(6'd9,  10'h008, 0, "R7 oldest page evicted");

    // flush and new base
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    run_req(6'd5, 10'h009, 0, "R8 miss after flush");
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    pt_base = 16'hFFF0;
    run_req(6'd20, 10'h3FF, 0, "R3 base wraps");
    run_req(6'd20, 10'h000, 1, "R2 hit after wrap refill");
    run_req(6'd63, 10'h3FF, 0, "R3 top page");

    repeat (5) @(negedge clk);
    check(q_maddr.size() == 0, "R3 all walks issued", q_maddr.size(), 0);
    check(done_cnt == pushed, "R9 one response each", done_cnt, pushed);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule